// File: doc/BRIEF.md
# Parallel SCSI Bus Arbitration Controller

This block handles the contention step an initiator goes through before it may select a target on a parallel SCSI bus. After a start request it watches the sampled BSY and SEL lines until the bus has been idle long enough. It then drives BSY and places its own ID bit on the data lines. Once an arbitration delay has elapsed, it checks whether any device with a higher ID is also contending. If the block wins in full arbitration-and-selection mode, it raises SEL and hands over to the selection logic through a done output. If it loses, it releases the bus at once.

Three status outputs show the outcome: contention in progress, lost and won. A fourth output shows bus reset status. It is the live OR of the bus RST line and a software reset request. The bus idle time and the arbitration delay are both counted in ticks of an external timer strobe, so the same block works at any core clock rate.

Top module: `scsi_arb_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, all outputs except rst_stat go low after that edge, and the won and lost flags clear.
- R2: After a start request the block waits until BSY and SEL are both inactive for FREE_TICKS timer ticks (default 4). Either line going active restarts the count. Until the count completes, nothing is driven onto the bus.
- R3: While contending, bsy_out is 1, data_out is the one-hot ID (bit own_id set, all other bits clear), sel_out is 0 and arb_busy is 1.
- R4: Contention is lost when sel_in is seen active during contention, or when any data_in bit numbered above own_id is set once ARB_TICKS ticks (default 24) have passed. Bit 7 has the highest priority. On the next edge the block sets arb_lost, clears arb_busy, releases bsy_out and clears data_out.
- R5: After ARB_TICKS ticks with no higher bit set and mode_full = 1, the block sets arb_won. It then drives sel_out, bsy_out and its ID bit, and holds sel_go high, until a new start or a bus reset.
- R6: A win with mode_full = 0 keeps bsy_out and the ID bit driven and raises sel_go. It never drives sel_out and sets neither arb_won nor arb_lost.
- R7: arb_won and arb_lost stay set until a start request is accepted. A start request is accepted only when the block is idle or has won, and is ignored while the block is waiting for bus free or contending. In full mode, exactly one of the two flags is set at the end of every attempt that is not aborted.
- R8: rst_stat equals rst_in OR sw_rst in the same cycle, with no latching.
- R9: rst_in high at a clock edge sends the block to idle and releases every bus output after that edge. arb_won and arb_lost keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to begin an arbitration attempt |
| mode_full | input | 1 | 1 = full arbitration-and-selection, 0 = arbitration only |
| own_id | input | 3 | This device's bus ID |
| bsy_in | input | 1 | Sampled BSY line, active high |
| sel_in | input | 1 | Sampled SEL line, active high |
| rst_in | input | 1 | Sampled bus RST line, active high |
| data_in | input | 8 | Sampled data lines, active high |
| tick | input | 1 | Single-cycle timer strobe |
| sw_rst | input | 1 | Software bus reset request |
| bsy_out | output | 1 | Drive BSY |
| sel_out | output | 1 | Drive SEL |
| data_out | output | 8 | Data line drive (own ID bit) |
| arb_busy | output | 1 | Contention in progress |
| arb_lost | output | 1 | Sticky lost flag |
| arb_won | output | 1 | Sticky won flag |
| sel_go | output | 1 | Hand-over to selection logic |
| rst_stat | output | 1 | Live bus reset status |

## Verification
The assertions assume the following about the inputs:
- own_id is stable from the start request until the attempt ends.
- tick is a strobe.
- sel_in during contention comes only from other devices, because the block never drives SEL while contending.

The bench meets these assumptions in three ways:
- It changes own_id only between attempts.
- It forms the sampled bus lines as the OR of the block's own drive and separate "other device" stimulus.
- It raises the foreign SEL only inside a contention window, which gives the loss by SEL.

// File: rtl/scsi_arb_pkg.sv
// Shared types for the arbitration controller.
package scsi_arb_pkg;
    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_WAIT_FREE,
        ARB_CONTEND,
        ARB_WON,
        ARB_HOLD
    } arb_state_e;
endpackage

// File: rtl/scsi_arb_tick_cnt.sv
// Saturating tick counter. It counts tick strobes up to LIMIT and flags when
// LIMIT is reached. A clear input forces it back to zero.
// Assumes LIMIT >= 1 and that tick is a strobe.
module scsi_arb_tick_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic reached
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    // Count ticks until the limit is reached; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign reached = (cnt == LIM);

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !reached);
endmodule

// File: rtl/scsi_arb_prio.sv
// Priority resolution. It turns the own ID into a one-hot lane and reports
// whether any lane numbered above the own ID is set on the sampled data lines.
// The highest lane has the highest priority.
module scsi_arb_prio #(
    parameter int ID_W = 3,
    localparam int LANES = 1 << ID_W
) (
    input  logic [ID_W-1:0]  own_id,
    input  logic [LANES-1:0] lanes,
    output logic [LANES-1:0] own_onehot,
    output logic             higher_seen
);
    logic [LANES-1:0] above;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Own lane select and the mask of lanes above it.
        assign own_onehot[i] = (own_id == ID_W'(i));
        assign above[i]      = (own_id < ID_W'(i));
    end

    assign higher_seen = |(lanes & above);
endmodule

// File: rtl/scsi_arb_fsm.sv
// Arbitration sequencer. It moves through wait-for-bus-free, contention and
// win states, and keeps the sticky won and lost flags.
// Assumes that sel_in, while contending, is driven only by other devices.
module scsi_arb_fsm
    import scsi_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       mode_full,
    input  logic       bsy_in,
    input  logic       sel_in,
    input  logic       rst_in,
    input  logic       free_reached,
    input  logic       delay_reached,
    input  logic       higher_seen,
    output arb_state_e state,
    output logic       won,
    output logic       lost
);
    arb_state_e nxt;
    logic       can_start;
    logic       bus_idle;

    assign can_start = (state == ARB_IDLE) || (state == ARB_WON) || (state == ARB_HOLD);
    assign bus_idle  = !bsy_in && !sel_in;

    // Next-state selection; a bus reset overrides every other transition.
    always_comb begin
        nxt = state;
        case (state)
            ARB_IDLE, ARB_WON, ARB_HOLD:
                if (start_req) nxt = ARB_WAIT_FREE;
            ARB_WAIT_FREE:
                if (free_reached && bus_idle) nxt = ARB_CONTEND;
            ARB_CONTEND:
                if (sel_in)
                    nxt = ARB_IDLE;
                else if (delay_reached)
                    nxt = higher_seen ? ARB_IDLE : (mode_full ? ARB_WON : ARB_HOLD);
            default:
                nxt = ARB_IDLE;
        endcase
        if (rst_in) nxt = ARB_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ARB_IDLE;
        else        state <= nxt;
    end

    // Sticky outcome flags, cleared when a new attempt is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            won  <= 1'b0;
            lost <= 1'b0;
        end else if (!rst_in) begin
            if (can_start && start_req) begin
                won  <= 1'b0;
                lost <= 1'b0;
            end else if (state == ARB_CONTEND) begin
                if (sel_in || (delay_reached && higher_seen))
                    lost <= 1'b1;
                else if (delay_reached && mode_full)
                    won <= 1'b1;
            end
        end
    end

    assert_free_before_contend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_CONTEND && $past(state) != ARB_CONTEND)
            |-> $past(free_reached && !bsy_in && !sel_in));
    assert_sel_loses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_CONTEND && sel_in && !rst_in) |=> (lost && state == ARB_IDLE));
    assert_won_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(won) |-> $past(mode_full));
    assert_hold_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_HOLD) |-> (!won && !lost));
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(won && lost));
    assert_reset_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_in |=> (state == ARB_IDLE));
endmodule

// File: rtl/scsi_arb_ctrl.sv
// Top of the initiator-side arbitration controller. It wires the bus-free
// counter, the arbitration delay counter, priority resolution and the
// sequencer, and drives the bus and status outputs.
// Assumes that the bus inputs are already synchronised to clk.
module scsi_arb_ctrl
    import scsi_arb_pkg::*;
#(
    parameter int ID_W       = 3,
    parameter int FREE_TICKS = 4,
    parameter int ARB_TICKS  = 24,
    localparam int LANES     = 1 << ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             mode_full,
    input  logic [ID_W-1:0]  own_id,
    input  logic             bsy_in,
    input  logic             sel_in,
    input  logic             rst_in,
    input  logic [LANES-1:0] data_in,
    input  logic             tick,
    input  logic             sw_rst,
    output logic             bsy_out,
    output logic             sel_out,
    output logic [LANES-1:0] data_out,
    output logic             arb_busy,
    output logic             arb_lost,
    output logic             arb_won,
    output logic             sel_go,
    output logic             rst_stat
);
    arb_state_e       state;
    logic             free_reached;
    logic             delay_reached;
    logic             higher_seen;
    logic [LANES-1:0] own_onehot;
    logic             on_bus;

    scsi_arb_tick_cnt #(.LIMIT(FREE_TICKS)) u_free_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state != ARB_WAIT_FREE) || bsy_in || sel_in),
        .tick    (tick),
        .reached (free_reached)
    );

    scsi_arb_tick_cnt #(.LIMIT(ARB_TICKS)) u_delay_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state != ARB_CONTEND),
        .tick    (tick),
        .reached (delay_reached)
    );

    scsi_arb_prio #(.ID_W(ID_W)) u_prio (
        .own_id      (own_id),
        .lanes       (data_in),
        .own_onehot  (own_onehot),
        .higher_seen (higher_seen)
    );

    scsi_arb_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_req     (start_req),
        .mode_full     (mode_full),
        .bsy_in        (bsy_in),
        .sel_in        (sel_in),
        .rst_in        (rst_in),
        .free_reached  (free_reached),
        .delay_reached (delay_reached),
        .higher_seen   (higher_seen),
        .state         (state),
        .won           (arb_won),
        .lost          (arb_lost)
    );

    // Bus drive follows the sequencer state.
    always_comb begin
        on_bus   = (state == ARB_CONTEND) || (state == ARB_WON) || (state == ARB_HOLD);
        bsy_out  = on_bus;
        data_out = on_bus ? own_onehot : '0;
        sel_out  = (state == ARB_WON);
        arb_busy = (state == ARB_CONTEND);
        sel_go   = (state == ARB_WON) || (state == ARB_HOLD);
    end

    assign rst_stat = rst_in | sw_rst;

    assert_contend_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arb_busy |-> (bsy_out && !sel_out && $onehot0(data_out) && data_out != '0));
    assert_release_on_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (!bsy_out && data_out == '0 && !arb_busy));
    assert_won_drives_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_won) |-> (sel_out && bsy_out && sel_go));
endmodule

// File: tb/scsi_arb_ctrl_tb.sv
// Bench: a behavioural reference model is stepped once per cycle and compared
// with every output.
module scsi_arb_ctrl_tb;
    localparam int FREE = 4;
    localparam int DLY  = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0, mode_full = 1'b1, rst_in = 1'b0, sw_rst = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] own_id = 3'd0;
    logic       oth_bsy = 1'b0, oth_sel = 1'b0;
    logic [7:0] oth_data = 8'h00;
    logic       bsy_out, sel_out, arb_busy, arb_lost, arb_won, sel_go, rst_stat;
    logic [7:0] data_out;
    wire        bsy_in  = bsy_out | oth_bsy;
    wire        sel_in  = sel_out | oth_sel;
    wire  [7:0] data_in = data_out | oth_data;

    int n_checks = 0, n_fail = 0, cycles = 0;
    // Model state: 0 idle, 1 wait-free, 2 contend, 3 won, 4 hold.
    int m_st = 0, m_free = 0, m_dly = 0;
    bit m_won = 0, m_lost = 0;

    scsi_arb_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .mode_full(mode_full),
        .own_id(own_id), .bsy_in(bsy_in), .sel_in(sel_in), .rst_in(rst_in),
        .data_in(data_in), .tick(tick), .sw_rst(sw_rst), .bsy_out(bsy_out),
        .sel_out(sel_out), .data_out(data_out), .arb_busy(arb_busy),
        .arb_lost(arb_lost), .arb_won(arb_won), .sel_go(sel_go), .rst_stat(rst_stat)
    );

    always #4 clk = ~clk;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    // Compare the outputs with the model, then step the model.
    always @(negedge clk) begin
        bit on_bus;
        bit hi;
        int n_st;
        bit n_won, n_lost;
        cycles++;
        on_bus = (m_st == 2 || m_st == 3 || m_st == 4);
        check(bsy_out, on_bus, (m_st == 1) ? "R2 bsy" : "R3 bsy");
        check(data_out, on_bus ? (8'h01 << own_id) : 8'h00, "R3 data");
        check(arb_busy, m_st == 2, "R3 busy");
        check(sel_out, m_st == 3, "R5 sel");
        check(sel_go, m_st == 3 || m_st == 4, "R6 go");
        check(arb_won, m_won, "R5 won");
        check(arb_lost, m_lost, "R4 lost");
        check(rst_stat, rst_in | sw_rst, "R8 rst_stat");
        if (!rst_n) begin
            m_st = 0; m_free = 0; m_dly = 0; m_won = 0; m_lost = 0;
        end else begin
            n_st = m_st; n_won = m_won; n_lost = m_lost;
            hi = ((data_in >> (int'(own_id) + 1)) != 8'h00);
            case (m_st)
                0, 3, 4: if (start_req) begin n_st = 1; n_won = 0; n_lost = 0; end
                1: if (m_free == FREE && !bsy_in && !sel_in) n_st = 2;
                2: if (sel_in) begin n_st = 0; n_lost = 1; end
                   else if (m_dly == DLY) begin
                       if (hi) begin n_st = 0; n_lost = 1; end
                       else if (mode_full) begin n_st = 3; n_won = 1; end
                       else n_st = 4;
                   end
                default: n_st = 0;
            endcase
            if (rst_in) begin n_st = 0; n_won = m_won; n_lost = m_lost; end
            if (m_st != 1 || bsy_in || sel_in) m_free = 0;
            else if (tick && m_free < FREE) m_free++;
            if (m_st != 2) m_dly = 0;
            else if (tick && m_dly < DLY) m_dly++;
            m_st = n_st; m_won = n_won; m_lost = n_lost;
        end
    end

    // Timer strobe on alternate cycles.
    always @(posedge clk) begin
        #1;
        tick = ~tick;
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start();
        @(posedge clk); #1 start_req = 1'b1;
        @(posedge clk); #1 start_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: an expired timer counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state.
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R5, R2: full-mode win; a lower foreign bit does not matter.
        own_id = 3'd3; mode_full = 1'b1; oth_data = 8'h02;
        start();
        idle(80);
        // R2, R7, R4: restart from won. Foreign BSY restarts the idle count,
        // a start during contention is ignored, and a higher bit loses.
        own_id = 3'd5; oth_data = 8'h00;
        start();
        idle(3);
        oth_bsy = 1'b1; idle(2); oth_bsy = 1'b0;
        idle(20);
        start();
        oth_data = 8'h80;
        idle(80);
        oth_data = 8'h00;
        // R4: loss by foreign SEL during contention.
        own_id = 3'd2;
        start();
        idle(30);
        oth_sel = 1'b1; idle(3); oth_sel = 1'b0;
        idle(5);
        // R6: arbitration-only win.
        mode_full = 1'b0; own_id = 3'd6; oth_data = 8'h01;
        start();
        idle(80);
        // R9: bus reset aborts, flags kept; then a fresh full-mode win.
        mode_full = 1'b1; own_id = 3'd7; oth_data = 8'h7F;
        start();
        idle(30);
        rst_in = 1'b1; idle(1); rst_in = 1'b0;
        idle(5);
        start();
        idle(80);
        // R9: bus reset while won releases everything.
        rst_in = 1'b1; idle(1); rst_in = 1'b0;
        idle(3);
        // R8: live reset status.
        sw_rst = 1'b1; idle(2);
        rst_in = 1'b1; idle(1); rst_in = 1'b0;
        sw_rst = 1'b0; idle(3);
        // R1: reset in mid-attempt.
        start();
        idle(20);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        idle(4);
        finish_run();
    end
endmodule